// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Unit

This block turns a 32-bit virtual address into a 29-bit external address for one access at a time. It first sorts the address into a region and checks it against the current privilege level. It then either maps the address straight through or looks it up in a small fully associative table. Each table entry carries its own page size (1 KB, 4 KB, 64 KB or 1 MB) and an 8-bit space identifier. An entry may be marked shared so that it matches under any identifier.

A lookup is started by pulsing `req_valid` with the address, the privilege level, the current identifier and the translation enable. One cycle later `rsp_valid` pulses. With it comes exactly one outcome: hit, miss, multiple hit or address error. A hit also carries the physical address, the cacheable and write-through attributes, and a flag that marks control-register space. Software loads entries through a one-cycle write port. That port refuses any entry that would let a write-back cached mapping land on the card-interface area.

Top module: `mpx_xlate_unit`

## Requirements
- R1: After reset every table entry is invalid: `rsp_valid` and `wr_reject` are 0, and the first translated lookup reports a miss.
- R2: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. Whenever `rsp_valid` is high, exactly one of `rsp_hit`, `rsp_miss`, `rsp_multi`, `rsp_addr_err` is set.
- R3: In privileged mode, addresses 0x80000000–0x9FFFFFFF and 0xA0000000–0xBFFFFFFF hit directly with `rsp_paddr` = vaddr[28:0]. The first range is cacheable and the second is not; `rsp_wthru` = 0 and `rsp_ctrl` = 0 for both.
- R4: With `xlate_en` = 0, the ranges 0x00000000–0x7FFFFFFF and 0xC0000000–0xDFFFFFFF also hit directly with `rsp_paddr` = vaddr[28:0] and are cacheable. The table is not consulted.
- R5: With `xlate_en` = 1, those two ranges go through the table. Size code 0/1/2/3 selects 10/12/16/20 offset bits. An entry matches when vaddr bits above the offset equal `{wr_vpn,10'b0}` bits above the offset. The result takes `{wr_ppn,10'b0}` above the offset and vaddr below it.
- R6: A non-shared entry matches only when its identifier equals `cur_sid`. A shared entry matches under any `cur_sid`.
- R7: A translated lookup with no valid matching entry reports `rsp_miss`.
- R8: A translated lookup with two or more matching entries reports `rsp_multi`.
- R9: In user mode (`priv_mode` = 0), only vaddr[31] = 0 and 0xE0000000–0xE3FFFFFF are allowed. Any other address reports `rsp_addr_err`, whatever the table holds and whatever `xlate_en` is.
- R10: 0xE0000000–0xE3FFFFFF (store queue) hits directly as cacheable with `rsp_ctrl` = 0. The rest of 0xE0000000–0xFFFFFFFF hits directly, non-cacheable, with `rsp_ctrl` = 1. Both give `rsp_paddr` = vaddr[28:0].
- R11: A translated hit whose result lies in 0x1C000000–0x1FFFFFFF (paddr[28:26] = 7) reports `rsp_ctrl` = 1 with `rsp_cacheable` = 0 and `rsp_wthru` = 0.
- R12: A write whose ppn lies in 0x14000000–0x1BFFFFFF (paddr[28:26] = 5 or 6) with cacheable = 1 and write-through = 0 is refused. `wr_reject` pulses in the next cycle and the entry keeps its old content. All other writes are stored.
- R13: A single translated hit reports the matching entry's cacheable and write-through bits.
- R14: A lookup in the same cycle as a write to the matching entry sees the old entry. Lookups issued from the next cycle on see the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| xlate_en | input | 1 | Translation enable |
| priv_mode | input | 1 | 1 = privileged access, 0 = user access |
| cur_sid | input | 8 | Current space identifier |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual address to translate |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 3 | Entry index written |
| wr_vpn | input | 22 | Virtual page number (vaddr[31:10]) |
| wr_ppn | input | 19 | Physical page number (paddr[28:10]) |
| wr_size | input | 2 | Page size code: 0=1 KB, 1=4 KB, 2=64 KB, 3=1 MB |
| wr_sid | input | 8 | Space identifier of the entry |
| wr_valid | input | 1 | Entry valid bit |
| wr_shared | input | 1 | Entry ignores the identifier |
| wr_cache | input | 1 | Entry cacheable bit |
| wr_wthru | input | 1 | Entry write-through bit |
| wr_reject | output | 1 | Previous cycle's write was refused |
| rsp_valid | output | 1 | Lookup result strobe |
| rsp_hit | output | 1 | Physical address is valid |
| rsp_miss | output | 1 | No entry matched |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_addr_err | output | 1 | Access not allowed at this privilege |
| rsp_paddr | output | 29 | External address |
| rsp_cacheable | output | 1 | Access may be cached |
| rsp_wthru | output | 1 | Cached writes go through |
| rsp_ctrl | output | 1 | Access targets control-register space |

## Verification
The bench flips each address bit of every loaded entry in turn, so an offset mask off by one bit for any page size shows up as a wrong address or a false miss. It sweeps all 256 identifiers against a private entry and a shared one, which catches a design that ignores the shared bit or compares the identifier the wrong way. Region decoding is swept over every top nibble, both privilege levels and both enable settings, including the store-queue edges. A design that lets user mode through, or that translates with the enable clear, gives the wrong outcome there. Further cases cover overlapping entries, a translated result in area 7, refused card-area writes and a write that races a lookup. A design that loses the multiple-hit case, the control remap, the write guard or the old-content rule fails one of these.

// File: rtl/mpx_pkg.sv
package mpx_pkg;
  localparam int VA_W    = 32;
  localparam int PA_W    = 29;
  localparam int SID_W   = 8;
  localparam int MIN_OFF = 10;
  localparam int VPN_W   = VA_W - MIN_OFF;
  localparam int PPN_W   = PA_W - MIN_OFF;

  typedef enum logic [2:0] {
    RG_LOW, RG_DCACHE, RG_DUNC, RG_HIGH, RG_SQ, RG_CTRL
  } region_e;

  typedef struct packed {
    logic             valid;
    logic             shared;
    logic             cacheable;
    logic             wthru;
    logic [1:0]       size;
    logic [SID_W-1:0] sid;
    logic [VPN_W-1:0] vpn;
    logic [PPN_W-1:0] ppn;
  } entry_t;

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [1:0]       size;
    logic             cacheable;
    logic             wthru;
  } attr_t;

  // offset mask for a page size code
  function automatic logic [VA_W-1:0] off_mask(input logic [1:0] size);
    case (size)
      2'd0:    return 32'h0000_03FF;
      2'd1:    return 32'h0000_0FFF;
      2'd2:    return 32'h0000_FFFF;
      default: return 32'h000F_FFFF;
    endcase
  endfunction

  function automatic logic [PA_W-1:0] merge_pa(input logic [PPN_W-1:0] ppn,
                                               input logic [VA_W-1:0]  va,
                                               input logic [1:0]       size);
    logic [VA_W-1:0] m;
    m = off_mask(size);
    return ({ppn, {MIN_OFF{1'b0}}} & ~m[PA_W-1:0]) | (va[PA_W-1:0] & m[PA_W-1:0]);
  endfunction

  // areas 5 and 6 form the card interface window
  function automatic logic card_hazard(input logic [2:0] area,
                                       input logic cacheable,
                                       input logic wthru);
    return cacheable && !wthru && (area == 3'd5 || area == 3'd6);
  endfunction

  function automatic logic ctrl_area(input logic [2:0] area);
    return area == 3'd7;
  endfunction
endpackage

// File: rtl/mpx_region_dec.sv
module mpx_region_dec
  import mpx_pkg::*;
(
  input  logic       [5:0] va_top,
  input  logic             priv,
  input  logic             xl_en,
  output region_e          region,
  output logic             priv_fault,
  output logic             xlate_req
);
  always_comb begin
    if (!va_top[5])                region = RG_LOW;
    else if (va_top[5:3] == 3'b100) region = RG_DCACHE;
    else if (va_top[5:3] == 3'b101) region = RG_DUNC;
    else if (va_top[5:3] == 3'b110) region = RG_HIGH;
    else if (va_top[2:0] == 3'b000) region = RG_SQ;
    else                            region = RG_CTRL;
  end

  assign priv_fault = !priv && !(region == RG_LOW || region == RG_SQ);
  assign xlate_req  = xl_en && (region == RG_LOW || region == RG_HIGH);
endmodule

// File: rtl/mpx_tlb_entry.sv
module mpx_tlb_entry
  import mpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  entry_t           load_data,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [SID_W-1:0] lk_sid,
  output logic             hit,
  output attr_t            attr
);
  entry_t          q;
  logic [VA_W-1:0] om;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_data;
  end

  always_comb begin
    om  = off_mask(q.size);
    hit = q.valid && (q.shared || q.sid == lk_sid) &&
          (((lk_vpn ^ q.vpn) & ~om[VA_W-1:MIN_OFF]) == '0);
  end

  assign attr = '{ppn: q.ppn, size: q.size, cacheable: q.cacheable, wthru: q.wthru};
endmodule

// File: rtl/mpx_xlate_unit.sv
module mpx_xlate_unit
  import mpx_pkg::*;
#(
  parameter  int NENT  = 8,
  localparam int IDX_W = $clog2(NENT),
  localparam int CNT_W = $clog2(NENT + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                xlate_en,
  input  logic                priv_mode,
  input  logic [SID_W-1:0]    cur_sid,
  input  logic                req_valid,
  input  logic [VA_W-1:0]     req_vaddr,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [VPN_W-1:0]    wr_vpn,
  input  logic [PPN_W-1:0]    wr_ppn,
  input  logic [1:0]          wr_size,
  input  logic [SID_W-1:0]    wr_sid,
  input  logic                wr_valid,
  input  logic                wr_shared,
  input  logic                wr_cache,
  input  logic                wr_wthru,
  output logic                wr_reject,
  output logic                rsp_valid,
  output logic                rsp_hit,
  output logic                rsp_miss,
  output logic                rsp_multi,
  output logic                rsp_addr_err,
  output logic [PA_W-1:0]     rsp_paddr,
  output logic                rsp_cacheable,
  output logic                rsp_wthru,
  output logic                rsp_ctrl
);
  // named internal events, watched by the checker
  region_e          region;
  logic             priv_fault;
  logic             xlate_req;
  logic             wr_bad;
  logic             wr_commit;
  logic [NENT-1:0]  match_vec;
  logic [CNT_W-1:0] match_cnt;
  attr_t            ent_attr [NENT];
  attr_t            sel_attr;
  entry_t           wr_data;

  mpx_region_dec u_rdec (
    .va_top     (req_vaddr[VA_W-1:VA_W-6]),
    .priv       (priv_mode),
    .xl_en      (xlate_en),
    .region     (region),
    .priv_fault (priv_fault),
    .xlate_req  (xlate_req)
  );

  assign wr_bad    = wr_en && card_hazard(wr_ppn[PPN_W-1:PPN_W-3], wr_cache, wr_wthru);
  assign wr_commit = wr_en && !wr_bad;
  assign wr_data   = '{valid: wr_valid, shared: wr_shared, cacheable: wr_cache,
                       wthru: wr_wthru, size: wr_size, sid: wr_sid,
                       vpn: wr_vpn, ppn: wr_ppn};

  for (genvar g = 0; g < NENT; g++) begin : g_ent
    mpx_tlb_entry u_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (wr_commit && wr_idx == IDX_W'(g)),
      .load_data (wr_data),
      .lk_vpn    (req_vaddr[VA_W-1:MIN_OFF]),
      .lk_sid    (cur_sid),
      .hit       (match_vec[g]),
      .attr      (ent_attr[g])
    );
  end

  always_comb begin
    match_cnt = '0;
    sel_attr  = '0;
    for (int i = 0; i < NENT; i++) begin
      match_cnt = match_cnt + CNT_W'(match_vec[i]);
      if (match_vec[i]) sel_attr = sel_attr | ent_attr[i];
    end
  end

  logic            o_hit, o_miss, o_multi, o_err, o_c, o_wt, o_ctrl;
  logic [PA_W-1:0] o_pa;

  always_comb begin
    o_hit = 1'b0; o_miss = 1'b0; o_multi = 1'b0; o_err = 1'b0;
    o_c = 1'b0; o_wt = 1'b0; o_ctrl = 1'b0; o_pa = '0;
    if (priv_fault) begin
      o_err = 1'b1;
    end else if (xlate_req) begin
      if (match_cnt == '0)      o_miss  = 1'b1;
      else if (match_cnt > 1)   o_multi = 1'b1;
      else begin
        o_hit  = 1'b1;
        o_pa   = merge_pa(sel_attr.ppn, req_vaddr, sel_attr.size);
        o_ctrl = ctrl_area(o_pa[PA_W-1:PA_W-3]);
        o_c    = sel_attr.cacheable && !o_ctrl;
        o_wt   = sel_attr.wthru && !o_ctrl;
      end
    end else begin
      o_hit = 1'b1;
      o_pa  = req_vaddr[PA_W-1:0];
      case (region)
        RG_DUNC: o_c = 1'b0;
        RG_CTRL: o_ctrl = 1'b1;
        default: o_c = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_hit <= 1'b0; rsp_miss <= 1'b0; rsp_multi <= 1'b0;
      rsp_addr_err <= 1'b0; rsp_paddr <= '0; rsp_cacheable <= 1'b0;
      rsp_wthru <= 1'b0; rsp_ctrl <= 1'b0; wr_reject <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      wr_reject <= wr_bad;
      if (req_valid) begin
        rsp_hit <= o_hit; rsp_miss <= o_miss; rsp_multi <= o_multi;
        rsp_addr_err <= o_err; rsp_paddr <= o_pa; rsp_cacheable <= o_c;
        rsp_wthru <= o_wt; rsp_ctrl <= o_ctrl;
      end
    end
  end
endmodule

// File: rtl/mpx_xlate_chk.sv
module mpx_xlate_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [31:0]      req_vaddr,
  input logic             priv_mode,
  input logic             xlate_en,
  input logic             wr_en,
  input logic             wr_reject,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_miss,
  input logic             rsp_multi,
  input logic             rsp_addr_err,
  input logic [28:0]      rsp_paddr,
  input logic             rsp_cacheable,
  input logic             rsp_wthru,
  input logic             rsp_ctrl,
  input logic             xlate_req,
  input logic             priv_fault,
  input logic [CNT_W-1:0] match_cnt
);
  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_multi, rsp_addr_err}) == 1);
  assert_uncached_direct_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && priv_mode && req_vaddr[31:29] == 3'b101 |=>
      rsp_hit && !rsp_cacheable && rsp_paddr == $past(req_vaddr[28:0]));
  assert_no_xlate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && priv_mode && !xlate_en |=> rsp_hit && !rsp_miss && !rsp_multi);
  assert_multi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && xlate_req && !priv_fault && match_cnt > 1 |=> rsp_multi);
  assert_user_fault_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !priv_mode && req_vaddr[31] && req_vaddr[31:26] != 6'b111000
      |=> rsp_addr_err);
  assert_ctrl_uncached_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_ctrl |-> !rsp_cacheable && !rsp_wthru);
  assert_reject_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |-> $past(wr_en));
endmodule

bind mpx_xlate_unit mpx_xlate_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
  .priv_mode(priv_mode), .xlate_en(xlate_en), .wr_en(wr_en), .wr_reject(wr_reject),
  .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_multi(rsp_multi),
  .rsp_addr_err(rsp_addr_err), .rsp_paddr(rsp_paddr), .rsp_cacheable(rsp_cacheable),
  .rsp_wthru(rsp_wthru), .rsp_ctrl(rsp_ctrl), .xlate_req(xlate_req),
  .priv_fault(priv_fault), .match_cnt(match_cnt)
);

// File: tb/mpx_xlate_unit_tb.sv
module mpx_xlate_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xlate_en = 1'b0, priv_mode = 1'b1;
  logic [7:0]  cur_sid = '0;
  logic        req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_idx = '0;
  logic [21:0] wr_vpn = '0;
  logic [18:0] wr_ppn = '0;
  logic [1:0]  wr_size = '0;
  logic [7:0]  wr_sid = '0;
  logic        wr_valid = 1'b0, wr_shared = 1'b0, wr_cache = 1'b0, wr_wthru = 1'b0;
  logic        wr_reject, rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_addr_err;
  logic [28:0] rsp_paddr;
  logic        rsp_cacheable, rsp_wthru, rsp_ctrl;

  int n_vec = 0, n_bad = 0;

  always #5 clk = ~clk;

  mpx_xlate_unit u_dut (.*);

  // reference table
  logic        m_v [8], m_sh [8], m_c [8], m_wt [8];
  logic [1:0]  m_sz [8];
  logic [7:0]  m_sid [8];
  logic [21:0] m_vpn [8];
  logic [18:0] m_ppn [8];

  // expected response {hit,miss,multi,err,c,wt,ctrl,pa}
  logic [35:0] exp_r;

  function automatic int obits(input logic [1:0] s);
    return (s == 2'd0) ? 10 : (s == 2'd1) ? 12 : (s == 2'd2) ? 16 : 20;
  endfunction

  task automatic predict(input logic [31:0] va, input logic pv, input logic en,
                         input logic [7:0] sid);
    logic        is_sq;
    int          n, k, ob;
    logic [31:0] pa;
    logic        ctl;
    is_sq = (va[31:26] == 6'b111000);
    n = 0; k = 0;
    if (!pv && va[31] && !is_sq) begin
      exp_r = {4'b0001, 3'b000, 29'd0};
    end else if (en && (!va[31] || va[31:29] == 3'b110)) begin
      for (int i = 0; i < 8; i++) begin
        ob = obits(m_sz[i]);
        if (m_v[i] && (m_sh[i] || m_sid[i] == sid) &&
            ((va >> ob) == ({m_vpn[i], 10'b0} >> ob))) begin
          n++; k = i;
        end
      end
      if (n == 0)      exp_r = {4'b0100, 3'b000, 29'd0};
      else if (n > 1)  exp_r = {4'b0010, 3'b000, 29'd0};
      else begin
        ob  = obits(m_sz[k]);
        pa  = ((({3'b000, m_ppn[k], 10'b0}) >> ob) << ob) | (va % (32'd1 << ob));
        ctl = (pa >= 32'h1C00_0000);
        exp_r = {4'b1000, m_c[k] && !ctl, m_wt[k] && !ctl, ctl, pa[28:0]};
      end
    end else begin
      pa = va & 32'h1FFF_FFFF;
      if (va[31:29] == 3'b101)                exp_r = {4'b1000, 3'b000, pa[28:0]};
      else if (va[31:29] == 3'b111 && !is_sq) exp_r = {4'b1000, 3'b001, pa[28:0]};
      else                                    exp_r = {4'b1000, 3'b100, pa[28:0]};
    end
  endtask

  task automatic check(input string tag, input logic ok, input logic [63:0] got,
                       input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_rsp(input string tag, input logic [31:0] va);
    logic [36:0] got;
    got = {rsp_valid, rsp_hit, rsp_miss, rsp_multi, rsp_addr_err,
           rsp_cacheable, rsp_wthru, rsp_ctrl, rsp_paddr};
    check($sformatf("%s va=%h", tag, va), got == {1'b1, exp_r},
          64'(got), 64'({1'b1, exp_r}));
  endtask

  task automatic lookup(input string tag, input logic [31:0] va, input logic pv,
                        input logic en, input logic [7:0] sid);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; priv_mode = pv; xlate_en = en; cur_sid = sid;
    predict(va, pv, en, sid);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(tag, va);
  endtask

  task automatic load(input int idx, input logic [31:0] va, input logic [31:0] pa,
                      input logic [1:0] sz, input logic [7:0] sid, input logic v,
                      input logic sh, input logic c, input logic wt);
    logic rej;
    rej = c && !wt && (pa[28:26] == 3'd5 || pa[28:26] == 3'd6);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = 3'(idx); wr_vpn = va[31:10]; wr_ppn = pa[28:10];
    wr_size = sz; wr_sid = sid; wr_valid = v; wr_shared = sh; wr_cache = c; wr_wthru = wt;
    @(negedge clk);
    wr_en = 1'b0;
    check("R12 write guard", wr_reject == rej, 64'(wr_reject), 64'(rej));
    if (!rej) begin
      m_v[idx] = v; m_sh[idx] = sh; m_c[idx] = c; m_wt[idx] = wt; m_sz[idx] = sz;
      m_sid[idx] = sid; m_vpn[idx] = va[31:10]; m_ppn[idx] = pa[28:10];
    end
  endtask

  logic [31:0] base [6];
  logic [7:0]  bsid [6];

  initial begin
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 0; m_sh[i] = 0; m_c[i] = 0; m_wt[i] = 0; m_sz[i] = 0;
      m_sid[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0;
    end
    repeat (3) @(negedge clk);
    check("R1 reset rsp_valid", rsp_valid == 1'b0, 64'(rsp_valid), 64'd0);
    check("R1 reset wr_reject", wr_reject == 1'b0, 64'(wr_reject), 64'd0);
    rst_n = 1'b1;
    lookup("R1/R7 empty table", 32'h0001_2400, 1'b1, 1'b1, 8'h11);
    @(negedge clk);
    check("R2 idle strobe", rsp_valid == 1'b0, 64'(rsp_valid), 64'd0);

    base[0] = 32'h0001_2400; bsid[0] = 8'h11;
    base[1] = 32'h0020_3000; bsid[1] = 8'h22;
    base[2] = 32'hC012_0000; bsid[2] = 8'h11;
    base[3] = 32'h0730_0000; bsid[3] = 8'h33;
    base[4] = 32'hC050_0000; bsid[4] = 8'h99;
    base[5] = 32'h0450_0000; bsid[5] = 8'h11;
    load(0, base[0], 32'h0345_6800, 2'd0, bsid[0], 1, 0, 1, 0);
    load(1, base[1], 32'h0567_8000, 2'd1, bsid[1], 1, 0, 1, 1);
    load(2, base[2], 32'h0ABC_0000, 2'd2, bsid[2], 1, 0, 0, 0);
    load(3, base[3], 32'h0990_0000, 2'd3, bsid[3], 1, 0, 1, 1);
    load(4, base[4], 32'h0111_1000, 2'd1, bsid[4], 1, 1, 1, 0);
    load(5, base[5], 32'h1C10_0000, 2'd3, bsid[5], 1, 0, 1, 1);
    load(6, 32'h4000_0000, 32'h0000_0400, 2'd0, 8'h00, 1, 1, 0, 0);
    load(7, 32'h4000_0000, 32'h0000_0800, 2'd0, 8'h00, 1, 1, 0, 1);

    // R12: card-area hazards refused, entry 2 unchanged
    load(2, base[2], 32'h1400_0000, 2'd2, bsid[2], 1, 0, 1, 0);
    load(2, base[2], 32'h1BF0_0000, 2'd2, bsid[2], 1, 0, 1, 0);
    lookup("R12 entry kept", base[2] | 32'h0000_1234, 1'b1, 1'b1, bsid[2]);
    load(7, 32'h4000_0000, 32'h1800_0800, 2'd0, 8'h00, 1, 1, 1, 1);
    load(7, 32'h4000_0000, 32'h1400_0800, 2'd0, 8'h00, 1, 1, 0, 0);

    // R5/R11/R13: flip each address bit around every entry
    for (int e = 0; e < 6; e++) begin
      lookup("R5/R11/R13 base", base[e], 1'b1, 1'b1, bsid[e]);
      for (int b = 0; b < 32; b++)
        lookup("R5/R11/R13 bit", base[e] ^ (32'd1 << b), 1'b1, 1'b1, bsid[e]);
    end

    // R6: identifier sweep, private and shared entries
    for (int s = 0; s < 256; s++) begin
      lookup("R6 private", base[0] | 32'h0000_0155, 1'b1, 1'b1, 8'(s));
      lookup("R6 shared", base[4] | 32'h0000_0ABC, 1'b1, 1'b1, 8'(s));
    end

    // R8: overlapping entries
    lookup("R8 multi", 32'h4000_0123, 1'b1, 1'b1, 8'h55);
    lookup("R8 multi user", 32'h4000_03FF, 1'b0, 1'b1, 8'h00);

    // R3/R4/R9/R10: regions x privilege x enable
    for (int t = 0; t < 16; t++)
      for (int p = 0; p < 2; p++)
        for (int en = 0; en < 2; en++)
          lookup("R3/R4/R9/R10 region", {4'(t), 28'h001_2400}, 1'(p), 1'(en), 8'h11);
    for (int p = 0; p < 2; p++) begin
      lookup("R10/R9 sq low", 32'hE000_0040, 1'(p), 1'b1, 8'h11);
      lookup("R10/R9 sq high", 32'hE3FF_FFFC, 1'(p), 1'b1, 8'h11);
      lookup("R10/R9 ctrl", 32'hE400_0000, 1'(p), 1'b1, 8'h11);
      lookup("R3/R9 edge", 32'h9FFF_FFFF, 1'(p), 1'b1, 8'h11);
    end

    // R14: write racing a lookup sees old content
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = base[0]; priv_mode = 1'b1; xlate_en = 1'b1; cur_sid = bsid[0];
    wr_en = 1'b1; wr_idx = 3'd0; wr_vpn = base[0][31:10]; wr_valid = 1'b0;
    wr_cache = 1'b0; wr_wthru = 1'b0; wr_ppn = '0;
    predict(base[0], 1'b1, 1'b1, bsid[0]);
    @(negedge clk);
    req_valid = 1'b0; wr_en = 1'b0;
    check_rsp("R14 same cycle", base[0]);
    m_v[0] = 1'b0;
    lookup("R14 next cycle", base[0], 1'b1, 1'b1, bsid[0]);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule